// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block lets a clocked host fetch 16-bit words from an external asynchronous one-time-programmable ROM of 32K words. The ROM has two active-low controls. The select line powers the device up and picks it. The gate line turns its output drivers on. The sequencer accepts one request at a time through a ready/valid handshake and latches the 15-bit word address and a mode flag at that moment. It then walks the ROM pins through a fixed sequence:

1. Select the device.
2. Open the output gate once the select-to-gate lead has elapsed.
3. Wait out the remaining access time.
4. Sample the data bus.
5. Close both controls and let the bus float back before the next access.

Every delay is given in picoseconds and converted to clock cycles by rounding up. Between accesses the device is left deselected, which is its low-power standby. The bus is never sampled unless both controls are active.

When the mode flag requests an identifier read, a separate signature-select output is held high for as long as the device is selected. The external device then presents its identification code instead of array contents. The code depends on address bit 0, and the timing is unchanged.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset and whenever no request is being served, `rom_ce_n` and `rom_oe_n` are 1, `rom_sig_sel` is 0, `rsp_done` is 0 and `req_ready` is 1. `req_ready` is 1 only in that idle condition.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. Address and mode are latched on that edge, and later changes on `req_addr` or `req_sig` do not affect the access in flight.
- R3: `rom_ce_n` goes to 0 on the edge after acceptance. While it stays 0, `rom_addr` holds the accepted address unchanged.
- R4: `rom_oe_n` is 0 only while `rom_ce_n` is 0. It falls no sooner than LEAD = max(1, A − O) cycles after `rom_ce_n` falls, where A = ceil(T_AA_PS / CLK_PS) and O = ceil(T_OE_PS / CLK_PS).
- R5: At the sampling edge, the select line has been low for at least A cycles and the gate line for at least O cycles. With A > O ≥ 2, `rsp_done` is high in cycle A + 1 counted from the acceptance edge.
- R6: `rsp_done` is a one-cycle pulse. `rsp_data` carries the sampled word while it is high and holds it until the next pulse.
- R7: After sampling, both controls rise together. `rom_ce_n` then stays 1 for at least F = max(1, ceil(T_DF_PS / CLK_PS)) cycles before the next access, and `req_ready` stays 0 during that float time.
- R8: For an identifier read (`req_sig` = 1), `rom_sig_sel` is 1 exactly while `rom_ce_n` is 0; for a normal read it stays 0. A conforming device returns 16'h0020 when address bit 0 is 0 and 16'h000F when it is 1, and the sequencer delivers that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 15 | Word address of the request |
| req_sig | input | 1 | 1 = identifier read, 0 = array read |
| rsp_done | output | 1 | One-cycle strobe, response word valid |
| rsp_data | output | 16 | Word captured from the ROM |
| rom_addr | output | 15 | Address lines to the ROM |
| rom_ce_n | output | 1 | Device select, active low |
| rom_oe_n | output | 1 | Output gate, active low |
| rom_sig_sel | output | 1 | Identifier-code select toward the ROM |
| rom_dq | input | 16 | ROM data bus |

## Verification
The bench runs against a timed device model that drives unknown values until the address, select and gate delays have all elapsed. A sequencer that samples early therefore returns X, and a sequencer that cuts the latency by a cycle misses the exact arrival cycle of the done strobe. Back-to-back requests with `req_valid` held high probe the float gap: a design that skipped or shortened it would reselect the device within F cycles. Changing the request inputs mid-access catches a design that reads them live instead of latching them. Identifier reads at both values of address bit 0 check that signature-select is raised only for that mode and only while the device is selected.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/100ps
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_OE, ST_WAIT, ST_CAPT, ST_FLOAT
  } rd_state_e;

  // Picosecond delay to whole clock cycles, rounded up.
  function automatic int unsigned to_cycles(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Cycles with select low before the gate may open.
  function automatic int unsigned lead_cycles(input int unsigned aa, input int unsigned oe);
    return at_least_one((aa > oe) ? aa - oe : 0);
  endfunction

  // Cycles spent in the wait state (gate open, before capture cycle).
  function automatic int unsigned wait_cycles(input int unsigned oe);
    return at_least_one((oe > 1) ? oe - 1 : 0);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
`timescale 1ns/100ps
module rom_rd_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rom_rd_capture.sv
`timescale 1ns/100ps
module rom_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] bus,
  output logic              done,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= sample;
      if (sample) word <= bus;
    end
  end
endmodule

// File: rtl/rom_rd_ctrl.sv
`timescale 1ns/100ps
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_PS  = 10000,
  parameter int unsigned T_AA_PS = 35000,
  parameter int unsigned T_OE_PS = 18000,
  parameter int unsigned T_DF_PS = 18000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_sig,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_sig_sel,
  input  logic [DATA_W-1:0] rom_dq
);
  localparam int unsigned AA_CYC    = to_cycles(T_AA_PS, CLK_PS);
  localparam int unsigned OE_CYC    = to_cycles(T_OE_PS, CLK_PS);
  localparam int unsigned FLOAT_CYC = at_least_one(to_cycles(T_DF_PS, CLK_PS));
  localparam int unsigned LEAD_CYC  = lead_cycles(AA_CYC, OE_CYC);
  localparam int unsigned WAIT_CYC  = wait_cycles(OE_CYC);
  localparam int unsigned CNT_W     = $clog2(max3(LEAD_CYC, WAIT_CYC, FLOAT_CYC) + 1);

  rd_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              sig_q;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;

  // Named events for the checker.
  logic accept_evt, sample_evt, release_evt;
  assign accept_evt  = req_valid && req_ready;
  assign sample_evt  = (st_q == ST_CAPT);
  assign release_evt = (st_q == ST_FLOAT) && tmr_expired;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE:  if (req_valid) begin
                  st_d     = ST_SETUP;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(LEAD_CYC - 1);
                end
      ST_SETUP: if (tmr_expired) st_d = ST_OE;
      ST_OE:    begin
                  st_d     = ST_WAIT;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(WAIT_CYC - 1);
                end
      ST_WAIT:  if (tmr_expired) st_d = ST_CAPT;
      ST_CAPT:  begin
                  st_d     = ST_FLOAT;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(FLOAT_CYC - 1);
                end
      ST_FLOAT: if (tmr_expired) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      sig_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept_evt) begin
        addr_q <= req_addr;
        sig_q  <= req_sig;
      end
    end
  end

  rom_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  rom_rd_capture #(.DATA_W(DATA_W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample_evt),
    .bus    (rom_dq),
    .done   (rsp_done),
    .word   (rsp_data)
  );

  assign req_ready   = (st_q == ST_IDLE);
  assign rom_addr    = addr_q;
  assign rom_ce_n    = !(st_q inside {ST_SETUP, ST_OE, ST_WAIT, ST_CAPT});
  assign rom_oe_n    = !(st_q inside {ST_OE, ST_WAIT, ST_CAPT});
  assign rom_sig_sel = sig_q && !rom_ce_n;
endmodule

module rom_rd_ctrl_chk #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned LEAD_CYC  = 2,
  parameter int unsigned FLOAT_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_sig_sel
);
  logic [7:0] lo_cnt, hi_cnt;

  // Cycles with select low so far / high so far (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 8'hFF;
    end else begin
      lo_cnt <= rom_ce_n ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt <= !rom_ce_n ? 8'd0 : ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rom_ce_n && rom_oe_n && !rsp_done));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && !$past(rom_ce_n)) |-> $stable(rom_addr));

  assert_gate_needs_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);

  assert_gate_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_oe_n) |-> (lo_cnt >= 8'(LEAD_CYC)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (hi_cnt >= 8'(FLOAT_CYC)));

  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_ce_n) |-> $rose(rom_oe_n));

  assert_sig_in_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sig_sel |-> !rom_ce_n);
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
  .ADDR_W(ADDR_W), .LEAD_CYC(LEAD_CYC), .FLOAT_CYC(FLOAT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
  .rom_sig_sel(rom_sig_sel)
);

// File: tb/rom_rd_ctrl_test.sv
`timescale 1ns/100ps
module rom_rd_ctrl_test;
  localparam int CLK_PS = 4000;
  // Bench's own cycle figures: 35 ns, 18 ns, 18 ns at 4 ns.
  localparam int AA_C = (35000 + CLK_PS - 1) / CLK_PS;   // 9
  localparam int OE_C = (18000 + CLK_PS - 1) / CLK_PS;   // 5
  localparam int FL_C = (18000 + CLK_PS - 1) / CLK_PS;   // 5

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [14:0] req_addr = '0;
  logic        req_sig = 1'b0;
  logic        rsp_done;
  logic [15:0] rsp_data;
  logic [14:0] rom_addr;
  logic        rom_ce_n, rom_oe_n, rom_sig_sel;
  logic [15:0] dq_m;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rom_rd_ctrl #(.CLK_PS(CLK_PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_sig(req_sig), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_sig_sel(rom_sig_sel), .rom_dq(dq_m)
  );

  function automatic logic [15:0] pat(input logic [14:0] a);
    return {a[6:0], a[14:7], 1'b1} ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] id_code(input logic b0);
    return b0 ? 16'h000F : 16'h0020;
  endfunction

  // Timed device model: X until all access delays have passed.
  realtime t_a = 0.0, t_o = 0.0;
  always @(rom_addr or rom_ce_n or rom_sig_sel) t_a = $realtime;
  always @(negedge rom_oe_n) t_o = $realtime;
  initial begin
    dq_m = 'z;
    #0.5;
    forever begin
      if (rom_ce_n || rom_oe_n)                                  dq_m = 'z;
      else if (($realtime - t_a) < 35.0 || ($realtime - t_o) < 18.0) dq_m = 'x;
      else dq_m = rom_sig_sel ? id_code(rom_addr[0]) : pat(rom_addr);
      #1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request and observe the whole access.
  task automatic do_read(input logic [14:0] a, input logic s, input logic scribble,
                         output logic [15:0] data, output int lat, output int ce_lo,
                         output int oe_lo, output int sig_hi, output int addr_bad);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_sig = s;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scribble) begin req_addr = ~a; req_sig = ~s; end
    lat = 1; ce_lo = 0; oe_lo = 0; sig_hi = 0; addr_bad = 0;
    while (!rsp_done && lat < 200) begin
      if (!rom_ce_n) ce_lo++;
      if (!rom_oe_n) oe_lo++;
      if (rom_sig_sel) sig_hi++;
      if (!rom_ce_n && rom_addr !== a) addr_bad++;
      @(negedge clk); lat++;
    end
    lat--;
    data = rsp_data;
  endtask

  task automatic t_reset();
    check(rom_ce_n === 1'b1, "R1 ce_n idle", 32'(rom_ce_n), 1);
    check(rom_oe_n === 1'b1, "R1 oe_n idle", 32'(rom_oe_n), 1);
    check(req_ready === 1'b1, "R1 ready idle", 32'(req_ready), 1);
    check(rsp_done === 1'b0 && rom_sig_sel === 1'b0, "R1 done/sig idle",
          32'({rsp_done, rom_sig_sel}), 0);
  endtask

  task automatic t_normal(input logic [14:0] a);
    logic [15:0] d; int lat, cl, ol, sh, ab;
    do_read(a, 1'b0, 1'b0, d, lat, cl, ol, sh, ab);
    check(d === pat(a), "R5 data", 32'(d), 32'(pat(a)));
    check(lat == AA_C + 1, "R5 latency", 32'(lat), 32'(AA_C + 1));
    check(cl >= AA_C && ol >= OE_C, "R5 access windows", 32'(ol), 32'(OE_C));
    check(cl - ol >= AA_C - OE_C, "R4 gate lead", 32'(cl - ol), 32'(AA_C - OE_C));
    check(ab == 0, "R3 address hold", 32'(ab), 0);
    check(sh == 0, "R8 sig low on array read", 32'(sh), 0);
    check(rom_ce_n && rom_oe_n, "R7 both released", 32'({rom_ce_n, rom_oe_n}), 3);
    @(negedge clk);
    check(rsp_done === 1'b0, "R6 done one cycle", 32'(rsp_done), 0);
    check(rsp_data === pat(a), "R6 data held", 32'(rsp_data), 32'(pat(a)));
  endtask

  task automatic t_ident(input logic b0);
    logic [15:0] d; int lat, cl, ol, sh, ab;
    logic [14:0] a;
    a = {14'h1A2B, b0};
    do_read(a, 1'b1, 1'b0, d, lat, cl, ol, sh, ab);
    check(d === id_code(b0), "R8 id code", 32'(d), 32'(id_code(b0)));
    check(sh == cl, "R8 sig while selected", 32'(sh), 32'(cl));
    check(lat == AA_C + 1, "R8 id timing", 32'(lat), 32'(AA_C + 1));
  endtask

  task automatic t_scribble();
    logic [15:0] d; int lat, cl, ol, sh, ab;
    do_read(15'h2468, 1'b0, 1'b1, d, lat, cl, ol, sh, ab);
    check(d === pat(15'h2468), "R2 latched addr", 32'(d), 32'(pat(15'h2468)));
    check(ab == 0 && sh == 0, "R2 latched mode", 32'({ab[15:0], sh[15:0]}), 0);
  endtask

  task automatic t_back_to_back();
    int gap;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 15'h0101; req_sig = 1'b0;
    while (!rsp_done) @(negedge clk);
    check(req_ready === 1'b0, "R7 ready low in float", 32'(req_ready), 0);
    check(rsp_data === pat(15'h0101), "R2 first of pair", 32'(rsp_data), 32'(pat(15'h0101)));
    req_addr = 15'h0202;
    gap = 0;
    while (rom_ce_n && gap < 100) begin gap++; @(negedge clk); end
    req_valid = 1'b0;
    check(gap >= FL_C, "R7 float gap", 32'(gap), 32'(FL_C));
    while (!rsp_done) @(negedge clk);
    check(rsp_data === pat(15'h0202), "R2 second of pair", 32'(rsp_data), 32'(pat(15'h0202)));
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal(15'h0000);
    t_normal(15'h7FFF);
    t_normal(15'h1234);
    t_normal(15'h5555);
    t_ident(1'b0);
    t_ident(1'b1);
    t_scribble();
    t_back_to_back();
    repeat (FL_C + 2) @(negedge clk);
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule